// File: doc/BRIEF.md
# Carry-Flag Arithmetic and Rotate Unit

This block is the flag-coupled arithmetic slice of an integer datapath. It carries out seven operations on a destination operand and a source operand: add with carry, add with overflow detect, subtract with borrow, subtract with overflow detect, negate with borrow, and rotate left or right through a single status flag. One flag bit serves every operation. For each operation it is an input (carry-in, borrow-in or rotate fill bit), an output (carry, borrow, overflow or bit shifted out), or both. Subtraction always forms destination minus source.

The surrounding pipeline supplies the operands, a 3-bit operation code and the current flag value, and raises `valid` for one cycle per operation. On that clock edge the unit registers the new destination value and the new flag together. Decoding, register files and memory access are outside this block. The operand width is a parameter and defaults to 32 bits.

Top module: `cfa_unit`

## Requirements
- R1: Op code 0 (add with carry) loads result = (dst + src + t_in) mod 2^W. The flag becomes 1 exactly when the full sum reaches 2^W.
- R2: Op code 2 (subtract with borrow) loads result = (dst - src - t_in) mod 2^W. The flag becomes 1 exactly when dst < src + t_in.
- R3: Op code 1 (add with overflow detect) loads result = (dst + src) mod 2^W. The flag is 1 only when both operands have the same top bit and the result's top bit differs from it. Otherwise the flag is 0.
- R4: Op code 3 (subtract with overflow detect) loads result = (dst - src) mod 2^W. The flag is 1 only when the operand top bits differ and the result's top bit differs from dst's top bit. Otherwise the flag is 0.
- R5: Op code 4 (negate with borrow) loads result = (0 - src - t_in) mod 2^W and ignores dst. The flag becomes 1 when src is nonzero or t_in is 1.
- R6: Op code 5 (rotate left through flag) loads result = {dst[W-2:0], t_in}, and the flag becomes dst[W-1].
- R7: Op code 6 (rotate right through flag) loads result = {t_in, dst[W-1:1]}, and the flag becomes dst[0].
- R8: Op code 7 with valid high leaves both the result and the flag at their previous values.
- R9: While valid is low, the result and the flag hold their values. When valid is high, the outputs show the new values from the next clock edge.
- R10: A synchronous active-high reset clears both the result and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Strobe: apply the selected operation on this edge |
| op | input | 3 | Operation code (0..7, see requirements) |
| src | input | WIDTH | Source operand |
| dst | input | WIDTH | Destination operand |
| t_in | input | 1 | Current flag value |
| result | output | WIDTH | Registered new destination value |
| t_out | output | 1 | Registered new flag value |

## Verification
A wrong carry-in polarity or a wrong operand inversion in the shared adder shows up as a result that is off by one, or as an inverted flag. Either error appears in the cycle right after the strobe and only for some operand pairs, so each operation is swept across every operand value and both flag values. A fault in the load enable leaks a new value into the registers during idle or code-7 cycles. That fault appears one edge later as an output that has changed when it should have held.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    typedef enum logic [2:0] {
        OP_ADDC  = 3'd0,
        OP_ADDV  = 3'd1,
        OP_SUBC  = 3'd2,
        OP_SUBV  = 3'd3,
        OP_NEGC  = 3'd4,
        OP_ROTL  = 3'd5,
        OP_ROTR  = 3'd6,
        OP_NOP   = 3'd7
    } op_e;

    typedef enum logic {
        ROT_LEFT  = 1'b0,
        ROT_RIGHT = 1'b1
    } rot_dir_e;

    typedef struct packed {
        logic invert_src;   // subtract: adder sees ~src
        logic zero_dst;     // negate: adder sees 0 for dst
        logic chain_flag;   // flag feeds carry / borrow in
        logic ovf_mode;     // flag reports signed overflow
    } arith_ctl_t;

    function automatic logic is_rotate(op_e o);
        return (o == OP_ROTL) || (o == OP_ROTR);
    endfunction

    function automatic logic is_load(op_e o);
        return o != OP_NOP;
    endfunction

    function automatic arith_ctl_t decode_arith(op_e o);
        arith_ctl_t c;
        c.invert_src = (o == OP_SUBC) || (o == OP_SUBV) || (o == OP_NEGC);
        c.zero_dst   = (o == OP_NEGC);
        c.chain_flag = (o == OP_ADDC) || (o == OP_SUBC) || (o == OP_NEGC);
        c.ovf_mode   = (o == OP_ADDV) || (o == OP_SUBV);
        return c;
    endfunction

endpackage

// File: rtl/cfa_addsub.sv
module cfa_addsub
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  arith_ctl_t        ctl,
    input  logic [WIDTH-1:0]  src,
    input  logic [WIDTH-1:0]  dst,
    input  logic              t_in,
    output logic [WIDTH-1:0]  res,
    output logic              t_new
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] opa;
    logic [WIDTH-1:0] opb;
    logic             cin;
    logic [WIDTH:0]   sum;
    logic             carry_flag;
    logic             ovf_flag;

    always_comb begin
        opa = ctl.zero_dst   ? '0   : dst;
        opb = ctl.invert_src ? ~src : src;
        // a - b - t == a + ~b + ~t ; a - b == a + ~b + 1
        if (ctl.chain_flag)
            cin = ctl.invert_src ? ~t_in : t_in;
        else
            cin = ctl.invert_src;
        sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
        res = sum[MSB:0];
        // carry out of add; borrow of subtract is the missing carry
        carry_flag = ctl.invert_src ? ~sum[WIDTH] : sum[WIDTH];
        // same-sign adder inputs whose sum changes sign
        ovf_flag = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
        t_new = ctl.ovf_mode ? ovf_flag : carry_flag;
    end

endmodule

// File: rtl/cfa_rotate.sv
module cfa_rotate
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  rot_dir_e          dir,
    input  logic [WIDTH-1:0]  val,
    input  logic              t_in,
    output logic [WIDTH-1:0]  res,
    output logic              t_new
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] left_v;
    logic [WIDTH-1:0] right_v;

    assign left_v[0]    = t_in;
    assign right_v[MSB] = t_in;

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_bits
            assign left_v[i]    = val[i-1];
            assign right_v[i-1] = val[i];
        end
    endgenerate

    always_comb begin
        if (dir == ROT_LEFT) begin
            res   = left_v;
            t_new = val[MSB];
        end else begin
            res   = right_v;
            t_new = val[0];
        end
    end

endmodule

// File: rtl/cfa_state_reg.sv
module cfa_state_reg #(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WIDTH-1:0]  res_d,
    input  logic              t_d,
    output logic [WIDTH-1:0]  res_q,
    output logic              t_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            t_q   <= 1'b0;
        end else if (load) begin
            res_q <= res_d;
            t_q   <= t_d;
        end
    end

    // R10: reset leaves zeros in both registers
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (res_q == '0) && !t_q);

    // R9: without a load the state does not move
    a_r9_hold_no_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(res_q) && $stable(t_q));

endmodule

// File: rtl/cfa_unit.sv
module cfa_unit
    import cfa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [2:0]        op,
    input  logic [WIDTH-1:0]  src,
    input  logic [WIDTH-1:0]  dst,
    input  logic              t_in,
    output logic [WIDTH-1:0]  result,
    output logic              t_out
);
    localparam int MSB = WIDTH - 1;

    op_e              op_sel;
    arith_ctl_t       actl;
    rot_dir_e         rdir;
    logic [WIDTH-1:0] arith_res;
    logic             arith_t;
    logic [WIDTH-1:0] rot_res;
    logic             rot_t;
    logic [WIDTH-1:0] next_res;
    logic             next_t;
    logic             load;

    assign op_sel = op_e'(op);
    assign actl   = decode_arith(op_sel);
    assign rdir   = (op_sel == OP_ROTR) ? ROT_RIGHT : ROT_LEFT;

    cfa_addsub #(.WIDTH(WIDTH)) u_addsub (
        .ctl   (actl),
        .src   (src),
        .dst   (dst),
        .t_in  (t_in),
        .res   (arith_res),
        .t_new (arith_t)
    );

    cfa_rotate #(.WIDTH(WIDTH)) u_rotate (
        .dir   (rdir),
        .val   (dst),
        .t_in  (t_in),
        .res   (rot_res),
        .t_new (rot_t)
    );

    always_comb begin
        if (is_rotate(op_sel)) begin
            next_res = rot_res;
            next_t   = rot_t;
        end else begin
            next_res = arith_res;
            next_t   = arith_t;
        end
    end

    assign load = valid && is_load(op_sel);

    cfa_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .res_d (next_res),
        .t_d   (next_t),
        .res_q (result),
        .t_q   (t_out)
    );

    // R1: flag and result together form the full-width sum
    a_r1_addc_sum: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd0) |=>
        {t_out, result} == ({1'b0, $past(dst)} + {1'b0, $past(src)}
                            + {{WIDTH{1'b0}}, $past(t_in)}));

    // R2: result plus src plus borrow-in rebuilds dst, with flag as wrap
    a_r2_subc_inverse: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd2) |=>
        ({1'b0, result} + {1'b0, $past(src)} + {{WIDTH{1'b0}}, $past(t_in)})
        == {t_out, $past(dst)});

    // R5: negation never depends on dst and clears flag only for 0 - 0 - 0
    a_r5_negc_flag: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd4) |=>
        t_out == (($past(src) != '0) || $past(t_in)));

    // R6: left rotate moves bits up and exchanges the flag
    a_r6_rotl: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd5) |=>
        result == {$past(dst[MSB-1:0]), $past(t_in)} && t_out == $past(dst[MSB]));

    // R7: right rotate moves bits down and exchanges the flag
    a_r7_rotr: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd6) |=>
        result == {$past(t_in), $past(dst[MSB:1])} && t_out == $past(dst[0]));

    // R8: code 7 is a no-operation even when strobed
    a_r8_code7_hold: assert property (@(posedge clk) disable iff (rst)
        (valid && op == 3'd7) |=> $stable(result) && $stable(t_out));

endmodule

// File: tb/cfa_unit_tb.sv
`timescale 1ns/1ps
module cfa_unit_tb;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         valid;
    logic [2:0]   op;
    logic [W-1:0] src;
    logic [W-1:0] dst;
    logic         t_in;
    logic [W-1:0] result;
    logic         t_out;

    int n_cmp  = 0;
    int n_bad  = 0;
    int exp_r  = 0;
    int exp_t  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cfa_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .valid(valid), .op(op),
        .src(src), .dst(dst), .t_in(t_in),
        .result(result), .t_out(t_out)
    );

    task automatic check(input string req);
        n_cmp++;
        if (int'(result) != exp_r || int'(t_out) != exp_t) begin
            n_bad++;
            $display("FAIL %s: op=%0d dst=%0d src=%0d t=%0d got res=%0d t=%0d exp res=%0d t=%0d",
                     req, op, dst, src, t_in, result, t_out, exp_r, exp_t);
        end
    endtask

    // Arithmetic model of one strobed operation on the model state
    task automatic model(input int o, input int d, input int s, input int t);
        int x;
        int sd, ss, sr;
        sd = (d >> (W-1)) & 1;
        ss = (s >> (W-1)) & 1;
        case (o)
            0: begin x = d + s + t; exp_r = x & MASK; exp_t = (x >> W) & 1; end
            1: begin x = (d + s) & MASK; sr = (x >> (W-1)) & 1;
                     exp_r = x; exp_t = (sd == ss && sr != sd) ? 1 : 0; end
            2: begin x = d - s - t; exp_r = x & MASK; exp_t = (x < 0) ? 1 : 0; end
            3: begin x = (d - s) & MASK; sr = (x >> (W-1)) & 1;
                     exp_r = x; exp_t = (sd != ss && sr != sd) ? 1 : 0; end
            4: begin x = 0 - s - t; exp_r = x & MASK; exp_t = (x < 0) ? 1 : 0; end
            5: begin exp_r = ((d << 1) | t) & MASK; exp_t = (d >> (W-1)) & 1; end
            6: begin exp_r = (d >> 1) | (t << (W-1)); exp_t = d & 1; end
            default: ;
        endcase
    endtask

    function automatic string tag(input int o);
        case (o)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic strobe(input int o, input int d, input int s, input int t);
        @(negedge clk);
        valid = 1'b1; op = 3'(o); dst = W'(d); src = W'(s); t_in = 1'(t);
        model(o, d, s, t);
        @(negedge clk);
        check(tag(o));
        valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; valid = 1'b0; op = '0; src = '0; dst = '0; t_in = 1'b0;
        repeat (3) @(negedge clk);
        exp_r = 0; exp_t = 0;
        check("R10");
        rst = 1'b0;

        // Exhaustive sweep over every code, operand pair and flag value
        for (int o = 0; o < 8; o++)
            for (int d = 0; d <= MASK; d++)
                for (int s = 0; s <= MASK; s++)
                    for (int t = 0; t < 2; t++)
                        strobe(o, d, s, t);

        // R5: dst has no effect on negate
        strobe(4, MASK, 3, 0);
        strobe(4, 0, 3, 0);

        // R8: code 7 after a nonzero result with flag set
        strobe(0, MASK, 1, 1);
        strobe(7, 0, 0, 0);
        strobe(7, 5, 9, 1);

        // R9: idle cycles with changing inputs leave state alone
        @(negedge clk);
        valid = 1'b0; op = 3'd0; dst = W'(3); src = W'(4); t_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            dst = W'(k); op = 3'(k);
            check("R9");
        end

        // R10: reset from a nonzero state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        exp_r = 0; exp_t = 0;
        check("R10");
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, got running exp done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule